// File: doc/BRIEF.md
# Processor Status Flags Register Unit

This block keeps the 32-bit status flags word of a processor core and applies the flag-manipulation operations that the instruction decoder sends it. A one-cycle strobe qualifies a 4-bit operation code. The operations set, clear or invert the carry flag, set or clear the direction flag, and set or clear the interrupt-enable flag. Two further operations move five arithmetic status flags between the flags word and an 8-bit byte operand. Two pop operations load the flags word back from a 16-bit or a 32-bit stack operand.

The unit drives a 16-bit and a 32-bit push image that always reflect the current flags, for a stack engine to write to memory. It also drives the string-index step direction, and a masked interrupt-accept signal formed from an external request and the interrupt-enable flag. Flag positions in the word are: carry 0, parity 2, auxiliary carry 4, zero 6, sign 7, interrupt-enable 9, direction 10, resume 16, virtual mode 17. Bit 1 is fixed at 1. The writable bits are 0, 2, 4, 6 to 14 and 16 to 21. All other bits are fixed at 0.

Top module: `flags_unit`

## Requirements
- R1: With op_valid high, code 1 sets bit 0 (carry), code 2 clears it and code 3 inverts it, on that clock edge. No other bit changes.
- R2: Code 4 writes bit 10 (direction) to 1 and code 5 writes it to 0. The output step_dec equals bit 10: 0 commands increment and 1 commands decrement.
- R3: Code 6 writes bit 9 (interrupt-enable) to 1 and code 7 writes it to 0. irq_accept is high only when irq_req is high and bit 9 is 1.
- R4: Code 8 loads byte_out with flags bits 7, 6, 4, 2, 0 in byte bits 7, 6, 4, 2, 0. Byte bits 5, 3 and 1 are 0, 1 and 0. The flags word does not change.
- R5: Code 9 copies byte_in bits 7, 6, 4, 2, 0 into flags bits 7, 6, 4, 2, 0. Every other flag keeps its value.
- R6: push16 equals flags_q[15:0], and push32 equals flags_q with bits 16 and 17 forced to 0. Both update on the same edge as flags_q.
- R7: Code 10 writes the writable bits among pop_in[15:0] into flags bits 15:0. Bits 31:16 keep their values.
- R8: Code 11 writes every writable bit from pop_in except bits 16 and 17, which keep their values.
- R9: Bit 1 of flags_q is always 1. Bits 3, 5, 15 and 22 to 31 are always 0, whatever is popped or stored.
- R10: Synchronous reset makes flags_q 32'h0000_0002 and byte_out 8'h00.
- R11: With op_valid low, or with code 0 or codes 12 to 15, flags_q and byte_out keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Qualifies op_code for this cycle |
| op_code | input | 4 | Flag operation code |
| byte_in | input | 8 | Byte operand for the store-byte operation |
| pop_in | input | 32 | Stack operand for the pop operations |
| irq_req | input | 1 | External hardware interrupt request |
| flags_q | output | 32 | Current flags word |
| byte_out | output | 8 | Byte image of the status flags |
| push16 | output | 16 | 16-bit push image |
| push32 | output | 32 | 32-bit push image |
| irq_accept | output | 1 | Interrupt request passed through the enable mask |
| step_dec | output | 1 | String index step direction, 1 for decrement |

## Verification
The assertions assume that op_code is meaningful only in cycles where op_valid is high. They also assume that pop_in and byte_in may carry any value, including ones in the fixed bit positions. The stimulus sends one operation at a time on the falling edge and holds op_valid low between some operations. It drives random opcodes, including the unused codes 12 to 15, together with random operands that often set fixed or protected bits. In this way the masking of reserved, resume and virtual-mode bits is exercised from the inputs.

// File: rtl/flags_pkg.sv
package flags_pkg;
  localparam int FLAG_W = 32;
  localparam int BYTE_W = 8;
  localparam int HALF_W = 16;

  localparam int POS_CF = 0;
  localparam int POS_PF = 2;
  localparam int POS_AF = 4;
  localparam int POS_ZF = 6;
  localparam int POS_SF = 7;
  localparam int POS_IF = 9;
  localparam int POS_DF = 10;
  localparam int POS_RF = 16;
  localparam int POS_VM = 17;

  localparam logic [FLAG_W-1:0] WRITE_MASK  = 32'h003F_7FD5;
  localparam logic [FLAG_W-1:0] FIXED_ONES  = 32'h0000_0002;
  localparam logic [FLAG_W-1:0] RESET_VALUE = FIXED_ONES;
  localparam logic [FLAG_W-1:0] PUSH_CLEAR  = (32'h1 << POS_RF) | (32'h1 << POS_VM);
  localparam logic [BYTE_W-1:0] BYTE_FILL   = 8'b0000_1000;

  localparam int LANES = 5;
  localparam int LANE_FLAG [LANES] = '{POS_SF, POS_ZF, POS_AF, POS_PF, POS_CF};
  localparam int LANE_BYTE [LANES] = '{7, 6, 4, 2, 0};

  typedef enum logic [3:0] {
    OP_NOP  = 4'd0,
    OP_SETC = 4'd1,
    OP_CLRC = 4'd2,
    OP_INVC = 4'd3,
    OP_SETD = 4'd4,
    OP_CLRD = 4'd5,
    OP_SETI = 4'd6,
    OP_CLRI = 4'd7,
    OP_RDB  = 4'd8,
    OP_WRB  = 4'd9,
    OP_POPW = 4'd10,
    OP_POPD = 4'd11
  } flag_op_e;
endpackage

// File: rtl/flags_byte_xfer.sv
module flags_byte_xfer
  import flags_pkg::*;
#(
  parameter int FW = FLAG_W,
  parameter int BW = BYTE_W
) (
  input  logic [FW-1:0] flags_i,
  input  logic [BW-1:0] byte_i,
  output logic [BW-1:0] gather_o,
  output logic [FW-1:0] scatter_mask_o,
  output logic [FW-1:0] scatter_val_o
);
  logic [LANES-1:0] g_bits;
  logic [LANES-1:0] s_bits;

  genvar ln;
  generate
    for (ln = 0; ln < LANES; ln++) begin : g_lane
      assign g_bits[ln] = flags_i[LANE_FLAG[ln]];
      assign s_bits[ln] = byte_i[LANE_BYTE[ln]];
    end
  endgenerate

  always_comb begin
    gather_o       = BYTE_FILL;
    scatter_mask_o = '0;
    scatter_val_o  = '0;
    for (int k = 0; k < LANES; k++) begin
      gather_o[LANE_BYTE[k]]       = g_bits[k];
      scatter_mask_o[LANE_FLAG[k]] = 1'b1;
      scatter_val_o[LANE_FLAG[k]]  = s_bits[k];
    end
  end
endmodule

// File: rtl/flags_next_state.sv
module flags_next_state
  import flags_pkg::*;
#(
  parameter int FW = FLAG_W,
  parameter int HW = HALF_W
) (
  input  logic [FW-1:0] cur_i,
  input  logic          valid_i,
  input  logic [3:0]    op_i,
  input  logic [FW-1:0] wr_mask_i,
  input  logic [FW-1:0] wr_val_i,
  input  logic [FW-1:0] pop_i,
  output logic [FW-1:0] nxt_o,
  output logic          load_byte_o
);
  localparam logic [FW-1:0] LOW_HALF  = {{(FW-HW){1'b0}}, {HW{1'b1}}};
  localparam logic [FW-1:0] POPW_MASK = WRITE_MASK & LOW_HALF;
  localparam logic [FW-1:0] POPD_MASK = WRITE_MASK & ~PUSH_CLEAR;

  logic [FW-1:0] raw;
  logic [FW-1:0] sel_mask;

  always_comb begin
    raw         = cur_i;
    sel_mask    = '0;
    load_byte_o = 1'b0;
    if (valid_i) begin
      case (flag_op_e'(op_i))
        OP_SETC: raw[POS_CF] = 1'b1;
        OP_CLRC: raw[POS_CF] = 1'b0;
        OP_INVC: raw[POS_CF] = ~cur_i[POS_CF];
        OP_SETD: raw[POS_DF] = 1'b1;
        OP_CLRD: raw[POS_DF] = 1'b0;
        OP_SETI: raw[POS_IF] = 1'b1;
        OP_CLRI: raw[POS_IF] = 1'b0;
        OP_RDB:  load_byte_o = 1'b1;
        OP_WRB:  sel_mask = wr_mask_i;
        OP_POPW: sel_mask = POPW_MASK;
        OP_POPD: sel_mask = POPD_MASK;
        default: raw = cur_i;
      endcase
      if (flag_op_e'(op_i) == OP_WRB) begin
        raw = (cur_i & ~sel_mask) | (wr_val_i & sel_mask);
      end else if (flag_op_e'(op_i) == OP_POPW || flag_op_e'(op_i) == OP_POPD) begin
        raw = (cur_i & ~sel_mask) | (pop_i & sel_mask);
      end
    end
    nxt_o = (raw & WRITE_MASK) | FIXED_ONES;
  end
endmodule

// File: rtl/flags_push_image.sv
module flags_push_image
  import flags_pkg::*;
#(
  parameter int FW = FLAG_W,
  parameter int HW = HALF_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [FW-1:0] nxt_i,
  output logic [HW-1:0] push16_o,
  output logic [FW-1:0] push32_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      push16_o <= RESET_VALUE[HW-1:0];
      push32_o <= RESET_VALUE & ~PUSH_CLEAR;
    end else begin
      push16_o <= nxt_i[HW-1:0];
      push32_o <= nxt_i & ~PUSH_CLEAR;
    end
  end
endmodule

// File: rtl/flags_unit.sv
module flags_unit
  import flags_pkg::*;
#(
  parameter int FW = FLAG_W,
  parameter int BW = BYTE_W,
  parameter int HW = HALF_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          op_valid,
  input  logic [3:0]    op_code,
  input  logic [BW-1:0] byte_in,
  input  logic [FW-1:0] pop_in,
  input  logic          irq_req,
  output logic [FW-1:0] flags_q,
  output logic [BW-1:0] byte_out,
  output logic [HW-1:0] push16,
  output logic [FW-1:0] push32,
  output logic          irq_accept,
  output logic          step_dec
);
  logic [BW-1:0] gather;
  logic [FW-1:0] sc_mask;
  logic [FW-1:0] sc_val;
  logic [FW-1:0] flags_nxt;
  logic          load_byte;

  flags_byte_xfer #(.FW(FW), .BW(BW)) xfer_i (
    .flags_i        (flags_q),
    .byte_i         (byte_in),
    .gather_o       (gather),
    .scatter_mask_o (sc_mask),
    .scatter_val_o  (sc_val)
  );

  flags_next_state #(.FW(FW), .HW(HW)) nxt_i (
    .cur_i       (flags_q),
    .valid_i     (op_valid),
    .op_i        (op_code),
    .wr_mask_i   (sc_mask),
    .wr_val_i    (sc_val),
    .pop_i       (pop_in),
    .nxt_o       (flags_nxt),
    .load_byte_o (load_byte)
  );

  flags_push_image #(.FW(FW), .HW(HW)) push_i (
    .clk      (clk),
    .rst      (rst),
    .nxt_i    (flags_nxt),
    .push16_o (push16),
    .push32_o (push32)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q  <= RESET_VALUE;
      byte_out <= '0;
    end else begin
      flags_q <= flags_nxt;
      if (load_byte) byte_out <= gather;
    end
  end

  assign step_dec   = flags_q[POS_DF];
  assign irq_accept = irq_req & flags_q[POS_IF];
endmodule

// File: rtl/flags_unit_chk.sv
module flags_unit_chk
  import flags_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic        op_valid,
  input logic [3:0]  op_code,
  input logic        irq_req,
  input logic [31:0] flags_q,
  input logic [15:0] push16,
  input logic [31:0] push32,
  input logic        irq_accept,
  input logic        step_dec
);
  p_setc_r1: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == 4'd1) |=> flags_q[0]);
  p_invc_r1: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == 4'd3) |=> (flags_q[0] != $past(flags_q[0])));
  p_setd_r2: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == 4'd4) |=> step_dec);
  p_clri_r3: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == 4'd7) |=> !irq_accept);
  p_mask_r3: assert property (@(posedge clk) disable iff (rst)
    !irq_req |-> !irq_accept);
  p_rdb_keep_r4: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == 4'd8) |=> $stable(flags_q));
  p_push_low_r6: assert property (@(posedge clk) disable iff (rst)
    push16 == flags_q[15:0]);
  p_push_hide_r6: assert property (@(posedge clk) disable iff (rst)
    push32[17:16] == 2'b00);
  p_fixed_r9: assert property (@(posedge clk) disable iff (rst)
    flags_q[1] && flags_q[3] == 1'b0 && flags_q[5] == 1'b0 && flags_q[15] == 1'b0);
  p_idle_r11: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> $stable(flags_q));
endmodule

bind flags_unit flags_unit_chk chk_i (
  .clk        (clk),
  .rst        (rst),
  .op_valid   (op_valid),
  .op_code    (op_code),
  .irq_req    (irq_req),
  .flags_q    (flags_q),
  .push16     (push16),
  .push32     (push32),
  .irq_accept (irq_accept),
  .step_dec   (step_dec)
);

// File: tb/flags_unit_tb_top.sv
`timescale 1ns/1ps
module flags_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_valid = 1'b0;
  logic [3:0]  op_code = 4'd0;
  logic [7:0]  byte_in = 8'd0;
  logic [31:0] pop_in = 32'd0;
  logic        irq_req = 1'b0;
  logic [31:0] flags_q;
  logic [7:0]  byte_out;
  logic [15:0] push16;
  logic [31:0] push32;
  logic        irq_accept;
  logic        step_dec;

  always #2.5 clk = ~clk;

  flags_unit dut_i (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .byte_in(byte_in), .pop_in(pop_in), .irq_req(irq_req),
    .flags_q(flags_q), .byte_out(byte_out), .push16(push16),
    .push32(push32), .irq_accept(irq_accept), .step_dec(step_dec)
  );

  typedef struct {
    logic [31:0] fl;
    logic [7:0]  by;
    string       tag;
  } exp_t;

  exp_t        sb_q[$];
  int          n_chk = 0;
  int          n_err = 0;
  logic [31:0] m_fl;
  logic [7:0]  m_by;
  logic [31:0] rng = 32'h1234_5678;
  bit          done = 1'b0;

  function automatic bit writable(int i);
    return (i == 0 || i == 2 || i == 4 || (i >= 6 && i <= 14) || (i >= 16 && i <= 21));
  endfunction

  function automatic string req_of(bit v, logic [3:0] op);
    if (!v) return "R11";
    case (op)
      4'd1, 4'd2, 4'd3: return "R1";
      4'd4, 4'd5: return "R2";
      4'd6, 4'd7: return "R3";
      4'd8: return "R4";
      4'd9: return "R5";
      4'd10: return "R7";
      4'd11: return "R8";
      default: return "R11";
    endcase
  endfunction

  function automatic logic [31:0] next_rand(logic [31:0] s);
    logic [31:0] x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_op(bit v, logic [3:0] op, logic [7:0] b, logic [31:0] p);
    exp_t e;
    @(negedge clk);
    op_valid = v; op_code = op; byte_in = b; pop_in = p;
    if (v) begin
      case (op)
        4'd1: m_fl[0] = 1'b1;
        4'd2: m_fl[0] = 1'b0;
        4'd3: m_fl[0] = ~m_fl[0];
        4'd4: m_fl[10] = 1'b1;
        4'd5: m_fl[10] = 1'b0;
        4'd6: m_fl[9] = 1'b1;
        4'd7: m_fl[9] = 1'b0;
        4'd8: m_by = {m_fl[7], m_fl[6], 1'b0, m_fl[4], 1'b1, m_fl[2], 1'b0, m_fl[0]};
        4'd9: begin
          m_fl[7] = b[7]; m_fl[6] = b[6]; m_fl[4] = b[4]; m_fl[2] = b[2]; m_fl[0] = b[0];
        end
        4'd10: for (int i = 0; i < 16; i++) if (writable(i)) m_fl[i] = p[i];
        4'd11: for (int i = 0; i < 32; i++) if (writable(i) && i != 16 && i != 17) m_fl[i] = p[i];
        default: ;
      endcase
    end
    e.fl = m_fl; e.by = m_by; e.tag = req_of(v, op);
    sb_q.push_back(e);
  endtask

  task automatic check_irq(logic r);
    @(negedge clk);
    op_valid = 1'b0;
    irq_req = r;
    #1;
    check("R3 irq", {63'd0, irq_accept}, {63'd0, r & m_fl[9]});
    check("R2 step", {63'd0, step_dec}, {63'd0, m_fl[10]});
    irq_req = 1'b0;
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (!rst && sb_q.size() > 0) begin
        e = sb_q.pop_front();
        check(e.tag, {32'd0, flags_q}, {32'd0, e.fl});
        check({e.tag, " byte"}, {56'd0, byte_out}, {56'd0, e.by});
        check("R6 push16", {48'd0, push16}, {48'd0, e.fl[15:0]});
        check("R6 push32", {32'd0, push32}, {32'd0, e.fl & 32'hFFFC_FFFF});
        check("R9 fixed", {32'd0, flags_q & 32'hFFC0_802A}, 64'h2);
      end
    end
  end

  initial begin : watchdog
    #(200000 * 5);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin : driver
    m_fl = 32'h2; m_by = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    irq_req = 1'b1;
    #1;
    check("R10 flags", {32'd0, flags_q}, 64'h2);
    check("R10 byte", {56'd0, byte_out}, 64'h0);
    check("R10 push32", {32'd0, push32}, 64'h2);
    check("R3 masked at reset", {63'd0, irq_accept}, 64'h0);
    irq_req = 1'b0;
    // R1 carry ops
    do_op(1, 4'd1, 8'h00, 0); do_op(1, 4'd3, 8'h00, 0); do_op(1, 4'd3, 8'h00, 0);
    do_op(1, 4'd2, 8'h00, 0);
    // R2 direction
    do_op(1, 4'd4, 8'h00, 0); check_irq(1'b1); do_op(1, 4'd5, 8'h00, 0); check_irq(1'b0);
    // R3 interrupt enable
    do_op(1, 4'd6, 8'h00, 0); check_irq(1'b1); check_irq(1'b0);
    do_op(1, 4'd7, 8'h00, 0); check_irq(1'b1);
    // R5 store byte, R4 load byte
    do_op(1, 4'd9, 8'hFF, 0); do_op(1, 4'd8, 8'h00, 0);
    do_op(1, 4'd9, 8'h2A, 0); do_op(1, 4'd8, 8'h00, 0);
    do_op(1, 4'd9, 8'hD5, 0); do_op(1, 4'd8, 8'h00, 0);
    // R7 / R8 pops with every bit set, then cleared
    do_op(1, 4'd10, 8'h00, 32'hFFFF_FFFF);
    do_op(1, 4'd11, 8'h00, 32'hFFFF_FFFF);
    do_op(1, 4'd10, 8'h00, 32'hFFFF_0000);
    do_op(1, 4'd11, 8'h00, 32'h0003_0000);
    // R11 idle strobe and unused codes
    do_op(0, 4'd1, 8'hFF, 32'hFFFF_FFFF); do_op(1, 4'd12, 8'hFF, 32'hFFFF_FFFF);
    do_op(1, 4'd15, 8'hFF, 32'hFFFF_FFFF); do_op(1, 4'd0, 8'h00, 0);
    for (int n = 0; n < 400; n++) begin
      logic [31:0] a;
      logic [31:0] b;
      rng = next_rand(rng); a = rng;
      rng = next_rand(rng); b = rng;
      do_op(a[31:28] != 4'd0, a[3:0], a[15:8], b);
      if (a[20]) check_irq(a[21]);
    end
    @(posedge clk); #2;
    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule